// File: doc/BRIEF.md
# Two-Wiper Serial Bus Register Controller

This block is the two-wire serial bus slave front end for a dual 256-position digitally controlled resistor. A system clock samples the bus clock and data lines through two-flop synchronizers. Edges are detected on the synchronized copies, and from them the block finds START and STOP conditions. After a START it collects an identification byte. The upper four bits of that byte must be the fixed device-type code `1010`, the next three bits must match three strap inputs, and the lowest bit selects read (1) or write (0). On a write, the next byte sets a register pointer, and each following byte is stored into the wiper register the pointer selects. On a read, the block shifts the selected register out, MSB first.

Both wiper registers come out of reset at mid-scale. A shutdown input forces both wiper outputs to a park code while it is high. The stored values are kept, so each wiper goes back to its own value when shutdown is released. The block never drives the data line high. It presents a single active-high pull-down enable that the pad turns into an open-drain driver.

Top module: `wiper_i2c_top`

## Requirements
- R1: During reset and after it, both wiper outputs read 8'h80 and the pull-down enable is low until the block itself acknowledges or transmits.
- R2: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. A STOP returns the block to idle. A START is honoured in any state, except during the first PWRUP_CYCLES clocks after reset, when it is ignored.
- R3: An identification byte with bits [7:4] = 4'b1010 and bits [3:1] = strapAddr is acknowledged by pulling data low during the ninth clock; bit 0 = 1 means read. Any other identification byte gets no acknowledge, and the block ignores all later bytes until the next START.
- R4: In a write, the byte after the identification byte loads the register pointer and is acknowledged. Each following byte is acknowledged and stored at the pointer: pointer 0 is wiper 0 and pointer 1 is wiper 1.
- R5: The pointer increments after every data byte, written or read, and it keeps its value across STOP and START, so a read without an address byte starts at the pointer left by the previous transfer.
- R6: In a read, the selected register is driven MSB first, each bit changing only while the clock is low. Data is released for the ninth clock. A master acknowledge (data low) moves on to the next byte; a master no-acknowledge ends driving.
- R7: Pointer values other than 0 and 1 are acknowledged on write but change no wiper, and a read at such a pointer returns 8'hFF (the line stays released).
- R8: While shutdownIn is high, both wiper outputs show 8'h00. Writes during shutdown update the stored values, and on release each output shows its stored value.
- R9: The pull-down enable changes only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (includes the block's own pull-down) |
| strapAddr | input | 3 | Strap value that identification bits [3:1] must match |
| shutdownIn | input | 1 | High parks both wipers at the shutdown code |
| wiper0Code | output | 8 | Tap code for wiper 0 |
| wiper1Code | output | 8 | Tap code for wiper 1 |
| sdaDriveLow | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
The bench drives a START inside the power-up window. A block that honoured it would acknowledge the following identification byte. After a wrong identification byte, the bench sends bytes shaped like an address and a data value; a block that failed to go deaf would acknowledge them and overwrite wiper 0. It reads through the pointer wrap into an unused address and issues a read without an address byte. An off-by-one pointer or a pointer cleared on STOP shows up there as the wrong byte or a stray acknowledge. It also writes during shutdown and releases: a block that discarded the stored value, or wrote through to the parked output, would show a wrong code in the per-clock comparison.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ID_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } ctlState_t;

  // Synchronized bus events handed to the control
  typedef struct packed {
    logic sclHigh;
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
  } busEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic writeReg;
    logic incAddr;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/wiper_bus_sync.sv
module wiper_bus_sync
  import wiper_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output busEvt_t evt
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclLast;
  logic              sdaLast;
  logic              sclS;
  logic              sdaS;

  // Idle bus is high on both lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclLast <= sclS;
      sdaLast <= sdaS;
    end
  end

  assign sclS = sclPipe[STAGES-1];
  assign sdaS = sdaPipe[STAGES-1];

  assign evt.sclHigh   = sclS;
  assign evt.sdaBit    = sdaS;
  assign evt.sclRise   = sclS & ~sclLast;
  assign evt.sclFall   = ~sclS & sclLast;
  assign evt.startSeen = sclS & sclLast & sdaLast & ~sdaS;
  assign evt.stopSeen  = sclS & sclLast & ~sdaLast & sdaS;

endmodule

// File: rtl/wiper_i2c_dp.sv
module wiper_i2c_dp
  import wiper_pkg::*;
#(
  parameter int                 NUM_WIPERS = 2,
  parameter int                 WIPER_W    = 8,
  parameter int                 STRAP_W    = 3,
  parameter logic [3:0]         DEV_TYPE   = 4'b1010,
  parameter logic [WIPER_W-1:0] RESET_CODE = 8'h80,
  parameter logic [WIPER_W-1:0] SHDN_CODE  = 8'h00
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     stb,
  input  logic                          sdaBit,
  input  logic [STRAP_W-1:0]            strapAddr,
  input  logic                          shutdownIn,
  output logic                          idHit,
  output logic                          rwBit,
  output logic                          txBit,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiperFlat
);

  logic [BYTE_W-1:0]  rxShift;
  logic [BYTE_W-1:0]  txShift;
  logic [BYTE_W-1:0]  addrReg;
  logic [BYTE_W-1:0]  rdByte;
  logic [WIPER_W-1:0] wiperReg [NUM_WIPERS];

  // Receive shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxShift <= '0;
    else if (stb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaBit};
  end

  assign idHit = (rxShift[7:4] == DEV_TYPE) && (rxShift[3:1] == strapAddr);
  assign rwBit = rxShift[0];

  // Register pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrReg <= '0;
    else if (stb.loadAddr) addrReg <= rxShift;
    else if (stb.incAddr)  addrReg <= addrReg + 1'b1;
  end

  // Wiper registers and parked outputs
  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_wiper
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wiperReg[w] <= RESET_CODE;
      else if (stb.writeReg && addrReg == BYTE_W'(w))
        wiperReg[w] <= rxShift[WIPER_W-1:0];
    end

    assign wiperFlat[w*WIPER_W +: WIPER_W] = shutdownIn ? SHDN_CODE : wiperReg[w];

    // R4 R7
    wiper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (addrReg != BYTE_W'(w) || !stb.writeReg) |=> wiperReg[w] == $past(wiperReg[w]));
  end

  // Read source: stored value, all ones for unused pointers
  always_comb begin
    rdByte = '1;
    for (int w = 0; w < NUM_WIPERS; w++)
      if (addrReg == BYTE_W'(w)) rdByte = BYTE_W'(wiperReg[w]);
  end

  // Transmit shifter, refilled with ones so a drained shifter releases the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txShift <= '1;
    else if (stb.loadTx)  txShift <= rdByte;
    else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
  end

  assign txBit = txShift[BYTE_W-1];

  // R4
  wr_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeReg && addrReg == '0) |=> wiperReg[0] == $past(rxShift[WIPER_W-1:0]));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incAddr && !stb.loadAddr) |=> addrReg == $past(addrReg) + 8'd1);

  // R6
  tx_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadTx, stb.shiftTx, stb.shiftIn}));

endmodule

// File: rtl/wiper_i2c_ctl.sv
module wiper_i2c_ctl
  import wiper_pkg::*;
#(
  parameter int PWRUP_CYCLES = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  busEvt_t   evt,
  input  logic      idHit,
  input  logic      rwBit,
  input  logic      txBit,
  output dpStrobe_t stb,
  output logic      sdaDriveLow
);

  localparam int PW_W = $clog2(PWRUP_CYCLES + 1);

  ctlState_t   state, stateNxt;
  logic [3:0]  bitCnt, cntNxt;
  logic        rdMode, rdNxt;
  logic        mAck, mAckNxt;
  logic [PW_W-1:0] pwrCnt;
  logic        pwrBusy;

  // Power-up window during which START is not honoured
  assign pwrBusy = (pwrCnt != PW_W'(PWRUP_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pwrCnt <= '0;
    else if (pwrBusy) pwrCnt <= pwrCnt + 1'b1;
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = bitCnt;
    rdNxt    = rdMode;
    mAckNxt  = mAck;
    stb      = '0;
    if (evt.stopSeen) begin
      stateNxt = ST_IDLE;
    end else if (evt.startSeen && !pwrBusy) begin
      stateNxt = ST_ID;
      cntNxt   = '0;
    end else begin
      case (state)
        ST_ID, ST_ADDR, ST_WR: begin
          if (evt.sclRise && bitCnt != 4'd8) begin
            stb.shiftIn = 1'b1;
            cntNxt      = bitCnt + 1'b1;
          end else if (evt.sclFall && bitCnt == 4'd8) begin
            cntNxt = '0;
            if (state == ST_ID) begin
              if (idHit) begin
                stateNxt = ST_ID_ACK;
                rdNxt    = rwBit;
              end else begin
                stateNxt = ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              stb.loadAddr = 1'b1;
              stateNxt     = ST_ADDR_ACK;
            end else begin
              stb.writeReg = 1'b1;
              stb.incAddr  = 1'b1;
              stateNxt     = ST_WR_ACK;
            end
          end
        end
        ST_ID_ACK: begin
          if (evt.sclFall) begin
            if (rdMode) begin
              stateNxt   = ST_RD;
              stb.loadTx = 1'b1;
            end else begin
              stateNxt = ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          if (evt.sclFall) stateNxt = ST_WR;
        end
        ST_RD: begin
          if (evt.sclRise && bitCnt != 4'd8) begin
            cntNxt = bitCnt + 1'b1;
          end else if (evt.sclFall) begin
            if (bitCnt == 4'd8) begin
              cntNxt      = '0;
              stb.incAddr = 1'b1;
              stateNxt    = ST_RD_ACK;
            end else if (bitCnt != 4'd0) begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (evt.sclRise) begin
            mAckNxt = ~evt.sdaBit;
          end else if (evt.sclFall) begin
            if (mAck) begin
              stateNxt   = ST_RD;
              stb.loadTx = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rdMode <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= cntNxt;
      rdMode <= rdNxt;
      mAck   <= mAckNxt;
    end
  end

  // Pull low in the three acknowledge slots and for zero bits of a read
  assign sdaDriveLow = (state == ST_ID_ACK) || (state == ST_ADDR_ACK) ||
                       (state == ST_WR_ACK) || (state == ST_RD && !txBit);

  // R9
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !evt.sclHigh);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopSeen |=> state == ST_IDLE);

  // R2
  pwrup_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrBusy |-> state == ST_IDLE);

  // R3
  id_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ID && evt.sclFall && bitCnt == 4'd8 && !idHit && !evt.startSeen && !evt.stopSeen)
      |=> (state == ST_IDLE && !sdaDriveLow));

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RD_ACK |-> !sdaDriveLow);

endmodule

// File: rtl/wiper_i2c_top.sv
module wiper_i2c_top
  import wiper_pkg::*;
#(
  parameter int         SYNC_STAGES  = 2,
  parameter int         PWRUP_CYCLES = 64,
  parameter logic [7:0] RESET_CODE   = 8'h80,
  parameter logic [7:0] SHDN_CODE    = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       shutdownIn,
  output logic [7:0] wiper0Code,
  output logic [7:0] wiper1Code,
  output logic       sdaDriveLow
);

  localparam int NUM_WIPERS = 2;
  localparam int WIPER_W    = 8;

  busEvt_t   evt;
  dpStrobe_t stb;
  logic      idHit;
  logic      rwBit;
  logic      txBit;
  logic [NUM_WIPERS*WIPER_W-1:0] wiperFlat;

  wiper_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .evt   (evt)
  );

  wiper_i2c_ctl #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .evt         (evt),
    .idHit       (idHit),
    .rwBit       (rwBit),
    .txBit       (txBit),
    .stb         (stb),
    .sdaDriveLow (sdaDriveLow)
  );

  wiper_i2c_dp #(
    .NUM_WIPERS (NUM_WIPERS),
    .WIPER_W    (WIPER_W),
    .STRAP_W    (3),
    .RESET_CODE (RESET_CODE),
    .SHDN_CODE  (SHDN_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .sdaBit     (evt.sdaBit),
    .strapAddr  (strapAddr),
    .shutdownIn (shutdownIn),
    .idHit      (idHit),
    .rwBit      (rwBit),
    .txBit      (txBit),
    .wiperFlat  (wiperFlat)
  );

  assign wiper0Code = wiperFlat[0*WIPER_W +: WIPER_W];
  assign wiper1Code = wiperFlat[1*WIPER_W +: WIPER_W];

endmodule

// File: tb/wiper_i2c_top_tb.sv
module wiper_i2c_top_tb;

  localparam int Q = 10;              // quarter bus period in system clocks
  localparam logic [7:0] ID_WR = 8'hAA;   // 1010 101 0
  localparam logic [7:0] ID_RD = 8'hAB;   // 1010 101 1
  localparam logic [7:0] ID_BAD = 8'hA8;  // strap field 100

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       shdn = 1'b0;
  logic [2:0] strap = 3'b101;
  logic [7:0] w0, w1;
  logic       drv;
  wire        sdaBus = sdaM & ~drv;

  wiper_i2c_top u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclM),
    .sdaIn       (sdaBus),
    .strapAddr   (strap),
    .shutdownIn  (shdn),
    .wiper0Code  (w0),
    .wiper1Code  (w1),
    .sdaDriveLow (drv)
  );

  int checks = 0;
  int fails  = 0;
  int modelReg [2];
  int modelAddr = 0;
  int settle = 0;
  bit modelOn = 1'b0;
  bit prevDrv = 1'b0;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Reference model compared on every clock
  always @(negedge clk) begin
    if (modelOn) begin
      if (settle > 0) settle--;
      else begin
        check(int'(w0) == (shdn ? 0 : modelReg[0]), "R4/R8 wiper0 per-clock", int'(w0), shdn ? 0 : modelReg[0]);
        check(int'(w1) == (shdn ? 0 : modelReg[1]), "R4/R8 wiper1 per-clock", int'(w1), shdn ? 0 : modelReg[1]);
      end
    end
    if (rstN && drv != prevDrv)
      check(sclM == 1'b0, "R9 pull-down changed while clock high", int'(sclM), 0);
    prevDrv = drv;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finishRun();
  end

  task automatic waitQ(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic bitOut(bit b);
    sdaM = b;    waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic bitIn(output bit b);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    b = sdaBus;  waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  // kind: 0 plain, 1 data write, 2 address byte
  task automatic sendByte(logic [7:0] v, int kind, output bit acked);
    bit b;
    for (int i = 7; i > 0; i--) bitOut(v[i]);
    sdaM = v[0]; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0;
    if (kind == 1) begin
      if (modelAddr < 2) modelReg[modelAddr] = int'(v);
      modelAddr = (modelAddr + 1) % 256;
      settle = 12;
    end else if (kind == 2) begin
      modelAddr = int'(v);
    end
    waitQ(1);
    bitIn(b);
    acked = ~b;
  endtask

  task automatic recvByte(bit ackIt, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      bitIn(b);
      v[i] = b;
    end
    modelAddr = (modelAddr + 1) % 256;
    bitOut(~ackIt);
  endtask

  function automatic int expRead();
    return (modelAddr < 2) ? modelReg[modelAddr] : 8'hFF;
  endfunction

  initial begin
    bit acked;
    logic [7:0] rv;
    int ev;
    modelReg[0] = 8'h80;
    modelReg[1] = 8'h80;

    // R1 reset state
    repeat (5) @(negedge clk);
    check(w0 == 8'h80, "R1 wiper0 in reset", int'(w0), 8'h80);
    check(w1 == 8'h80, "R1 wiper1 in reset", int'(w1), 8'h80);
    check(drv == 1'b0, "R1 pull-down in reset", int'(drv), 0);
    rstN = 1'b1;
    modelOn = 1'b1;

    // R2 START inside power-up window is ignored
    startCond();
    sendByte(ID_WR, 0, acked);
    check(!acked, "R2 start in power-up window acknowledged", int'(acked), 0);
    stopCond();
    check(drv == 1'b0, "R1 pull-down after power-up", int'(drv), 0);

    // R3 R4 R5 write both wipers
    startCond();
    sendByte(ID_WR, 0, acked);
    check(acked, "R3 matching write id ack", int'(acked), 1);
    sendByte(8'h00, 2, acked);
    check(acked, "R4 address byte ack", int'(acked), 1);
    sendByte(8'h3C, 1, acked);
    check(acked, "R4 data byte ack", int'(acked), 1);
    sendByte(8'hC5, 1, acked);
    check(acked, "R5 incremented data byte ack", int'(acked), 1);
    stopCond();
    check(w0 == 8'h3C, "R4 wiper0 written", int'(w0), 8'h3C);
    check(w1 == 8'hC5, "R5 wiper1 written via increment", int'(w1), 8'hC5);

    // R6 R5 R7 read with address and repeated start
    startCond();
    sendByte(ID_WR, 0, acked);
    sendByte(8'h00, 2, acked);
    startCond();
    sendByte(ID_RD, 0, acked);
    check(acked, "R3 matching read id ack", int'(acked), 1);
    ev = expRead();
    recvByte(1'b1, rv);
    check(int'(rv) == ev, "R6 read wiper0", int'(rv), ev);
    ev = expRead();
    recvByte(1'b1, rv);
    check(int'(rv) == ev, "R5 read increments to wiper1", int'(rv), ev);
    ev = expRead();
    recvByte(1'b0, rv);
    check(int'(rv) == ev, "R7 read of unused pointer", int'(rv), ev);
    waitQ(1);
    check(drv == 1'b0, "R6 released after master nack", int'(drv), 0);
    stopCond();

    // R7 write to unused pointer
    startCond();
    sendByte(ID_WR, 0, acked);
    sendByte(8'h07, 2, acked);
    sendByte(8'h55, 1, acked);
    check(acked, "R7 unused pointer write ack", int'(acked), 1);
    stopCond();
    check(w0 == 8'h3C && w1 == 8'hC5, "R7 wipers unchanged", int'({w0, w1}), 16'h3CC5);

    // R3 mismatched id then bytes shaped like address and data
    startCond();
    sendByte(ID_BAD, 0, acked);
    check(!acked, "R3 mismatched id nack", int'(acked), 0);
    sendByte(8'h00, 0, acked);
    check(!acked, "R3 byte after mismatch nack", int'(acked), 0);
    sendByte(8'h99, 0, acked);
    check(!acked, "R3 data after mismatch nack", int'(acked), 0);
    stopCond();
    check(w0 == 8'h3C, "R3 wiper0 untouched after mismatch", int'(w0), 8'h3C);

    // R5 pointer kept across STOP: set pointer 1, then read without address
    startCond();
    sendByte(ID_WR, 0, acked);
    sendByte(8'h01, 2, acked);
    stopCond();
    startCond();
    sendByte(ID_RD, 0, acked);
    ev = expRead();
    recvByte(1'b1, rv);
    check(int'(rv) == ev, "R5 read from retained pointer", int'(rv), ev);
    ev = expRead();
    recvByte(1'b0, rv);
    check(int'(rv) == ev, "R7 read past last wiper", int'(rv), ev);
    stopCond();

    // R8 shutdown park and restore
    shdn = 1'b1;
    settle = 4;
    waitQ(1);
    check(w0 == 8'h00 && w1 == 8'h00, "R8 parked outputs", int'({w0, w1}), 0);
    startCond();
    sendByte(ID_WR, 0, acked);
    sendByte(8'h00, 2, acked);
    sendByte(8'h11, 1, acked);
    check(acked, "R8 write during shutdown ack", int'(acked), 1);
    stopCond();
    check(w0 == 8'h00, "R8 still parked after write", int'(w0), 0);
    shdn = 1'b0;
    settle = 4;
    waitQ(1);
    check(w0 == 8'h11, "R8 wiper0 restored with new value", int'(w0), 8'h11);
    check(w1 == 8'hC5, "R8 wiper1 restored", int'(w1), 8'hC5);

    waitQ(4);
    finishRun();
  end

endmodule